// File: doc/BRIEF.md
# Pin Capture Packer with Chunk-Loss and Starvation Flags

This block samples a 12-bit pin bus at a programmable rate and gathers sixteen consecutive samples into a 256-bit chunk of 32 bytes. Each sample sits in its own 16-bit lane, and the four lane bits above the pins are always zero. A finished chunk moves to a burst writer in a single cycle, together with a running byte count. The writer issues one burst request for each chunk it takes. Its target address walks slot by slot through a circular buffer and returns to the base once the configured number of slots has been used, so a long capture overwrites the oldest data.

A chunk that finishes while the writer is still waiting for a memory acknowledge is discarded, but the byte count still advances past it. The receiving side compares the count carried by each accepted chunk with the count of the one before. A step larger than one chunk latches an overflow flag. Every finished burst sends a one-cycle notification to the host. The host polls the block from time to time, and a poll that finds no new notification since the previous poll latches an underflow flag. A start pulse clears all counts, the write slot and both flags. A stop pulse halts sampling. In one-shot mode, sampling ends by itself after a programmed number of chunks.

Top module: `pin_capture_packer`

## Requirements
- R1: Sample k of a chunk (k = 0 first) occupies `mem_data[16k+15:16k]`, with the pin value in bits 11:0 of that lane and bits 15:12 of every lane at zero.
- R2: After the clock edge that registers `start`, a sample is taken at the next edge and then at every `idle_cycles`+1 edges, so with zero idle cycles one sample is taken per clock.
- R3: The count sent with a chunk is 32 times the number of chunks produced before it since the last start, so the first chunk carries 0. Dropped chunks are included in this number.
- R4: An accepted chunk raises `mem_req` and holds `mem_addr`, `mem_data` and `mem_cnt` steady until the cycle in which `mem_ack` is high. The n-th burst after start (n = 0 first) goes to `base_addr` + 32·(n mod `buf_chunks`).
- R5: A chunk that completes while `mem_req` is high is discarded and never appears as a burst.
- R6: `overflow` becomes 1 when an accepted chunk's count exceeds the previous accepted chunk's count by more than 32, and it stays 1 until the next start.
- R7: `host_evt` is high for exactly the one cycle that follows each cycle with both `mem_req` and `mem_ack` high.
- R8: A `host_poll` that sees the same number of notifications as the previous poll (or as the start, for the first poll) sets `underflow`, which stays 1 until the next start.
- R9: `start` clears both flags, the counts and the write slot. `stop` deasserts `running` at the next edge and no later chunk is produced. With `one_shot` set, `running` falls at the edge that completes chunk number `chunk_limit`.
- R10: During reset, `running`, `mem_req`, `host_evt`, `overflow` and `underflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse: clear state and begin capture |
| stop | input | 1 | Pulse: end capture |
| one_shot | input | 1 | Stop by itself after `chunk_limit` chunks |
| chunk_limit | input | 16 | Chunks to capture in one-shot mode |
| idle_cycles | input | 8 | Idle clocks between two samples |
| buf_chunks | input | 16 | Circular buffer size in 32-byte slots |
| base_addr | input | 32 | Byte address of slot 0 |
| pins | input | 12 | Sampled pin bus |
| mem_req | output | 1 | Burst write request |
| mem_addr | output | 32 | Burst byte address |
| mem_data | output | 256 | Burst payload, sixteen 16-bit lanes |
| mem_cnt | output | 32 | Byte count carried with the chunk |
| mem_ack | input | 1 | Burst accepted by memory |
| host_evt | output | 1 | One-cycle notification per finished burst |
| host_poll | input | 1 | Host check for new notifications |
| running | output | 1 | Capture active |
| overflow | output | 1 | Sticky: chunk lost before the writer |
| underflow | output | 1 | Sticky: host polled with nothing new |

## Verification
The bench feeds random pin values every clock, under zero, small random and three-cycle idle gaps. Each burst payload is compared with the samples taken at the bench's own predicted sample edges, so a wrong lane order, a missing zero nibble or a sampling edge that is off by one shows up as a data mismatch. Memory acknowledges that come back quickly must give gap-free counts and a clear overflow flag. A memory that holds each burst for about 27 cycles while chunks arrive every 16 must give exactly every second chunk, with counts 0, 64 and 128 and the flag set. Buffer sizes of one to five slots test the address wrap. Two polls in a row with no burst in between separate a correct underflow latch from one that fires on every poll or never fires.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int PIN_W  = 12;
  localparam int HALF_W = 16;
  localparam int CNT_W  = 32;
  localparam int ADDR_W = 32;
  localparam int SLOT_W = 16;
  localparam int EVT_W  = 16;

  typedef logic [PIN_W-1:0]  pins_t;
  typedef logic [HALF_W-1:0] half_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [EVT_W-1:0]  evt_t;

  // pin bus widened to one storage lane, spare bits forced low
  function automatic half_t to_half(pins_t p);
    return {{(HALF_W-PIN_W){1'b0}}, p};
  endfunction

  // running byte count after one more chunk
  function automatic cnt_t count_after(cnt_t c, int unsigned bytes);
    return c + cnt_t'(bytes);
  endfunction

  // true when the step between two carried counts skips a chunk
  function automatic logic gap_exceeds(cnt_t prev, cnt_t cur, int unsigned bytes);
    return (cur - prev) > cnt_t'(bytes);
  endfunction

  // circular slot advance
  function automatic slot_t slot_next(slot_t s, slot_t size);
    slot_t n;
    n = s + slot_t'(1);
    return (n >= size) ? '0 : n;
  endfunction

  // byte address of a slot
  function automatic addr_t slot_addr(addr_t base, slot_t s, int unsigned bytes);
    return base + addr_t'(s) * addr_t'(bytes);
  endfunction
endpackage

// File: rtl/cap_sampler.sv
module cap_sampler
  import cap_pkg::*;
#(
  parameter int SPC   = 16,
  parameter int DIV_W = 8,
  parameter int LIM_W = 16,
  localparam int CHUNK_W = SPC * HALF_W,
  localparam int CHUNK_B = CHUNK_W / 8,
  localparam int IDX_W   = $clog2(SPC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               stop,
  input  logic               one_shot,
  input  logic [LIM_W-1:0]   chunk_limit,
  input  logic [DIV_W-1:0]   idle_cycles,
  input  pins_t              pins,
  output logic               running,
  output logic               sample_tick,
  output logic               chunk_vld,
  output logic [CHUNK_W-1:0] chunk_data,
  output cnt_t               chunk_cnt
);
  logic [DIV_W-1:0] div_q;
  logic [IDX_W-1:0] idx_q;
  logic [LIM_W-1:0] made_q;
  cnt_t             cnt_q;
  half_t            cur_half;
  logic             last_slot;
  logic             limit_hit;
  logic [CHUNK_W-1:0] packed_w;

  assign cur_half    = to_half(pins);
  assign sample_tick = running && (div_q == '0) && !start && !stop;
  assign last_slot   = (idx_q == IDX_W'(SPC-1));
  assign limit_hit   = one_shot && ((made_q + LIM_W'(1)) >= chunk_limit);

  // one holding register per earlier lane; the final lane comes straight from the pins
  for (genvar g = 0; g < SPC-1; g++) begin : g_lane
    half_t hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        hold_q <= '0;
      else if (sample_tick && idx_q == IDX_W'(g))
        hold_q <= cur_half;
    end
    assign packed_w[g*HALF_W +: HALF_W] = hold_q;
  end
  assign packed_w[(SPC-1)*HALF_W +: HALF_W] = cur_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b0;
      div_q      <= '0;
      idx_q      <= '0;
      made_q     <= '0;
      cnt_q      <= '0;
      chunk_vld  <= 1'b0;
      chunk_data <= '0;
      chunk_cnt  <= '0;
    end else begin
      chunk_vld <= 1'b0;
      if (start) begin
        running <= 1'b1;
        div_q   <= '0;
        idx_q   <= '0;
        made_q  <= '0;
        cnt_q   <= '0;
      end else if (stop) begin
        running <= 1'b0;
      end else if (sample_tick) begin
        div_q <= idle_cycles;
        if (last_slot) begin
          idx_q      <= '0;
          chunk_vld  <= 1'b1;
          chunk_data <= packed_w;
          chunk_cnt  <= cnt_q;
          cnt_q      <= count_after(cnt_q, CHUNK_B);
          made_q     <= made_q + LIM_W'(1);
          if (limit_hit) running <= 1'b0;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end else if (running) begin
        div_q <= div_q - DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/cap_writer.sv
module cap_writer
  import cap_pkg::*;
#(
  parameter int CHUNK_W = 256,
  localparam int CHUNK_B = CHUNK_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               chunk_vld,
  input  logic [CHUNK_W-1:0] chunk_data,
  input  cnt_t               chunk_cnt,
  input  addr_t              base_addr,
  input  slot_t              buf_chunks,
  input  logic               mem_ack,
  output logic               mem_req,
  output addr_t              mem_addr,
  output logic [CHUNK_W-1:0] mem_data,
  output cnt_t               mem_cnt,
  output logic               host_evt,
  output logic               accept,
  output logic               drop,
  output logic               burst_done
);
  slot_t slot_q;

  assign accept     = chunk_vld && !mem_req && !start;
  assign drop       = chunk_vld && mem_req;
  assign burst_done = mem_req && mem_ack && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
      mem_cnt  <= '0;
      slot_q   <= '0;
      host_evt <= 1'b0;
    end else begin
      host_evt <= burst_done;
      if (start) begin
        mem_req <= 1'b0;
        slot_q  <= '0;
      end else if (accept) begin
        mem_req  <= 1'b1;
        mem_addr <= slot_addr(base_addr, slot_q, CHUNK_B);
        mem_data <= chunk_data;
        mem_cnt  <= chunk_cnt;
      end else if (burst_done) begin
        mem_req <= 1'b0;
        slot_q  <= slot_next(slot_q, buf_chunks);
      end
    end
  end
endmodule

// File: rtl/cap_monitor.sv
module cap_monitor
  import cap_pkg::*;
#(
  parameter int CHUNK_B = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic accept,
  input  cnt_t acc_cnt,
  input  logic host_evt,
  input  logic host_poll,
  output logic overflow,
  output logic underflow,
  output logic gap_seen,
  output logic poll_empty
);
  logic have_prev;
  cnt_t prev_cnt;
  evt_t evt_q;
  evt_t poll_snap;

  assign gap_seen   = accept && have_prev && gap_exceeds(prev_cnt, acc_cnt, CHUNK_B);
  assign poll_empty = host_poll && (evt_q == poll_snap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_cnt  <= '0;
      evt_q     <= '0;
      poll_snap <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else if (start) begin
      have_prev <= 1'b0;
      prev_cnt  <= '0;
      evt_q     <= '0;
      poll_snap <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (accept) begin
        prev_cnt  <= acc_cnt;
        have_prev <= 1'b1;
      end
      if (gap_seen) overflow <= 1'b1;
      if (host_evt) evt_q <= evt_q + evt_t'(1);
      if (host_poll) poll_snap <= evt_q;
      if (poll_empty) underflow <= 1'b1;
    end
  end
endmodule

// File: rtl/pin_capture_packer.sv
module pin_capture_packer
  import cap_pkg::*;
#(
  parameter int SPC   = 16,
  parameter int DIV_W = 8,
  parameter int LIM_W = 16,
  localparam int CHUNK_W = SPC * HALF_W,
  localparam int CHUNK_B = CHUNK_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               stop,
  input  logic               one_shot,
  input  logic [LIM_W-1:0]   chunk_limit,
  input  logic [DIV_W-1:0]   idle_cycles,
  input  logic [SLOT_W-1:0]  buf_chunks,
  input  logic [ADDR_W-1:0]  base_addr,
  input  logic [PIN_W-1:0]   pins,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [CHUNK_W-1:0] mem_data,
  output logic [CNT_W-1:0]   mem_cnt,
  input  logic               mem_ack,
  output logic               host_evt,
  input  logic               host_poll,
  output logic               running,
  output logic               overflow,
  output logic               underflow
);
  logic               sample_tick;
  logic               chunk_vld;
  logic [CHUNK_W-1:0] chunk_data;
  cnt_t               chunk_cnt;
  logic               accept;
  logic               drop;
  logic               burst_done;
  logic               gap_seen;
  logic               poll_empty;

  cap_sampler #(.SPC(SPC), .DIV_W(DIV_W), .LIM_W(LIM_W)) u_sampler (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .one_shot(one_shot), .chunk_limit(chunk_limit), .idle_cycles(idle_cycles),
    .pins(pins), .running(running), .sample_tick(sample_tick),
    .chunk_vld(chunk_vld), .chunk_data(chunk_data), .chunk_cnt(chunk_cnt)
  );

  cap_writer #(.CHUNK_W(CHUNK_W)) u_writer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .chunk_vld(chunk_vld), .chunk_data(chunk_data), .chunk_cnt(chunk_cnt),
    .base_addr(base_addr), .buf_chunks(buf_chunks), .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_cnt(mem_cnt),
    .host_evt(host_evt), .accept(accept), .drop(drop), .burst_done(burst_done)
  );

  cap_monitor #(.CHUNK_B(CHUNK_B)) u_monitor (
    .clk(clk), .rst_n(rst_n), .start(start),
    .accept(accept), .acc_cnt(chunk_cnt),
    .host_evt(host_evt), .host_poll(host_poll),
    .overflow(overflow), .underflow(underflow),
    .gap_seen(gap_seen), .poll_empty(poll_empty)
  );
endmodule

// File: rtl/pin_capture_packer_chk.sv
module pin_capture_packer_chk
  import cap_pkg::*;
#(
  parameter int CHUNK_W = 256,
  parameter int DIV_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               stop,
  input logic               running,
  input logic               mem_req,
  input logic               mem_ack,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [CHUNK_W-1:0] mem_data,
  input logic               host_evt,
  input logic               overflow,
  input logic               underflow,
  input logic               chunk_vld,
  input logic               sample_tick,
  input logic [DIV_W-1:0]   idle_cycles
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !start) |=> (mem_req && $stable(mem_addr) && $stable(mem_data))); // R4
  AST_DROP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_vld && mem_req && !start) |=> $stable(mem_addr)); // R5
  AST_EVT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !start) |=> host_evt); // R7
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_evt |=> !host_evt); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !start) |=> overflow); // R6
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !start) |=> underflow); // R8
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !running); // R9
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && idle_cycles != '0 && $stable(idle_cycles)) |=> !sample_tick); // R2
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!running && !mem_req && !overflow && !underflow)); // R10
endmodule

bind pin_capture_packer pin_capture_packer_chk #(.CHUNK_W(CHUNK_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .running(running),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_data(mem_data),
  .host_evt(host_evt), .overflow(overflow), .underflow(underflow),
  .chunk_vld(chunk_vld), .sample_tick(sample_tick), .idle_cycles(idle_cycles)
);

// File: tb/pin_capture_packer_tb.sv
module pin_capture_packer_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, stop = 1'b0, one_shot = 1'b0;
  logic [15:0]  chunk_limit = '0;
  logic [7:0]   idle_cycles = '0;
  logic [15:0]  buf_chunks = 16'd4;
  logic [31:0]  base_addr = 32'h1000_0040;
  logic [11:0]  pins = '0;
  logic         mem_req, host_evt, running, overflow, underflow;
  logic [31:0]  mem_addr, mem_cnt;
  logic [255:0] mem_data;
  logic         mem_ack = 1'b0;
  logic         host_poll = 1'b0;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pin_capture_packer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .one_shot(one_shot),
    .chunk_limit(chunk_limit), .idle_cycles(idle_cycles), .buf_chunks(buf_chunks),
    .base_addr(base_addr), .pins(pins), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_cnt(mem_cnt), .mem_ack(mem_ack), .host_evt(host_evt),
    .host_poll(host_poll), .running(running), .overflow(overflow), .underflow(underflow)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected burst payload from sixteen pin values
  function automatic logic [255:0] pack_lanes(logic [11:0] s [16]);
    logic [255:0] v = '0;
    for (int i = 0; i < 16; i++) v[16*i +: 16] = {4'h0, s[i]};
    return v;
  endfunction

  function automatic bit spare_bits_clear(logic [255:0] v);
    for (int i = 0; i < 16; i++) if (v[16*i+12 +: 4] != 4'h0) return 1'b0;
    return 1'b1;
  endfunction

  // ---------------- bench reference of the sampling side ----------------
  bit           pend_start = 0, pend_stop = 0, run_m = 0;
  int           edge_cnt = 0, lane_m = 0, made_m = 0;
  logic [11:0]  lane_buf [16];
  logic [255:0] exp_chunk [64];

  always @(posedge clk) begin
    if (pend_start) begin
      pend_start = 0; pend_stop = 0;
      run_m = 1; edge_cnt = 0; lane_m = 0; made_m = 0;
    end else if (pend_stop) begin
      pend_stop = 0; run_m = 0;
    end else if (run_m) begin
      edge_cnt++;
      if ((edge_cnt - 1) % (int'(idle_cycles) + 1) == 0) begin
        lane_buf[lane_m] = pins;
        lane_m++;
        if (lane_m == 16) begin
          exp_chunk[made_m % 64] = pack_lanes(lane_buf);
          made_m++; lane_m = 0;
          if (one_shot && made_m >= int'(chunk_limit)) run_m = 0;
        end
      end
    end
  end

  // ---------------- pin driver and memory responder ----------------
  int ack_lat = 2, wait_c = 0, bursts = 0, evt_seen = 0, prev_idx = -1, last_idx = -1;

  always @(negedge clk) begin
    pins <= 12'($urandom);
    if (host_evt) evt_seen++;
    if (mem_ack) begin
      mem_ack = 1'b0; wait_c = 0;
    end else if (mem_req) begin
      wait_c++;
      if (wait_c > ack_lat) begin
        int idx;
        idx = int'(mem_cnt / 32);
        mem_ack = 1'b1;
        check(mem_cnt % 32 == 0 && idx < made_m, "R3", "count within produced range", mem_cnt, made_m*32);
        if (bursts == 0) check(idx == 0, "R3", "first chunk count", mem_cnt, 0);
        else check(idx > prev_idx, "R3", "count increases", idx, prev_idx + 1);
        check(mem_data == exp_chunk[idx % 64], "R2", "payload matches samples", longint'(mem_data[63:0]), longint'(exp_chunk[idx % 64][63:0]));
        check(spare_bits_clear(mem_data), "R1", "upper lane bits zero", longint'(mem_data[63:0]), 0);
        check(mem_addr == base_addr + 32'((bursts % int'(buf_chunks)) * 32), "R4", "burst address", mem_addr,
              longint'(base_addr) + (bursts % int'(buf_chunks)) * 32);
        prev_idx = idx; last_idx = idx;
        bursts++;
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic begin_run(bit os, int lim, int idle, int bufn, int lat);
    @(negedge clk);
    one_shot = os; chunk_limit = 16'(lim); idle_cycles = 8'(idle);
    buf_chunks = 16'(bufn); ack_lat = lat;
    bursts = 0; evt_seen = 0; prev_idx = -1; last_idx = -1;
    start = 1'b1; pend_start = 1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic end_run();
    @(negedge clk);
    stop = 1'b1; pend_stop = 1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 8) begin
      @(negedge clk);
      if (!running && !mem_req) quiet++; else quiet = 0;
    end
  endtask

  task automatic poll_host();
    @(negedge clk); host_poll = 1'b1;
    @(negedge clk); host_poll = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C4A));
    repeat (3) @(negedge clk);
    check(!running && !mem_req && !host_evt, "R10", "idle outputs in reset", {running, mem_req, host_evt}, 0);
    check(!overflow && !underflow, "R10", "flags low in reset", {overflow, underflow}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed: full rate, fast memory, wrap at four slots
    begin_run(1, 6, 0, 4, 2);
    wait_idle();
    check(bursts == 6, "R9", "one-shot chunk total", bursts, 6);
    check(!running, "R9", "one-shot ends capture", running, 0);
    check(!overflow, "R6", "no loss with fast memory", overflow, 0);
    check(evt_seen == bursts, "R7", "one notification per burst", evt_seen, bursts);

    // random short runs, memory always fast enough
    for (int r = 0; r < 4; r++) begin
      int lim, idl, bn, lt;
      lim = 2 + int'($urandom % 4); idl = int'($urandom % 3);
      bn = 1 + int'($urandom % 4);  lt = int'($urandom % 7);
      begin_run(1, lim, idl, bn, lt);
      wait_idle();
      check(bursts == lim, "R9", "random run chunk total", bursts, lim);
      check(!overflow, "R6", "random run no loss", overflow, 0);
      check(evt_seen == bursts, "R7", "random run notifications", evt_seen, bursts);
    end

    // directed: slower sampling, three-slot wrap
    begin_run(1, 5, 3, 3, 1);
    wait_idle();
    check(bursts == 5, "R2", "idle-gap run chunk total", bursts, 5);

    // directed: slow memory drops every second chunk
    begin_run(1, 6, 0, 8, 25);
    wait_idle();
    check(bursts == 3, "R5", "busy writer drops chunks", bursts, 3);
    check(last_idx == 4, "R3", "count skips dropped chunks", last_idx * 32, 128);
    check(overflow, "R6", "gap raises overflow", overflow, 1);
    repeat (5) @(negedge clk);
    check(overflow, "R6", "overflow stays set", overflow, 1);

    // start clears the flag
    begin_run(0, 0, 0, 4, 2);
    check(!overflow, "R9", "start clears overflow", overflow, 0);
    end_run();
    wait_idle();

    // continuous run halted by stop
    ack_lat = 2;
    begin_run(0, 0, 1, 5, 2);
    repeat (200) @(negedge clk);
    end_run();
    check(!running, "R9", "stop halts capture", running, 0);
    wait_idle();
    begin
      int b0;
      b0 = bursts;
      repeat (100) @(negedge clk);
      check(bursts == b0 && b0 > 0, "R9", "no burst after stop", bursts, b0);
    end

    // host polling
    poll_host();
    check(!underflow, "R8", "poll after new events", underflow, 0);
    poll_host();
    check(underflow, "R8", "poll with nothing new", underflow, 1);
    begin_run(0, 0, 0, 4, 2);
    check(!underflow, "R9", "start clears underflow", underflow, 0);
    poll_host();
    check(underflow, "R8", "first poll with no burst", underflow, 1);
    end_run();
    wait_idle();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule